// File: doc/BRIEF.md
# Cache residency length monitor

This block models the tag side of a small direct-mapped cache and attaches a reference counter to every line. Each time a memory block is placed in a line, the counter for that line starts again. Every load or store that the resident block serves adds one to it, and that includes the reference that caused the insertion. When the block leaves the line, the block emits the count as one residency length. No data is stored. The model only tracks which block sits in each line and how much use it has had.

A processor trace drives the block with one reference per cycle, as a strobe plus a byte address. A single stream of records carries the results. Each record has a valid pulse, the line index and the residency length. An end-of-run strobe flushes every residency that is still open, so that no length is lost. The same memory block can appear in many records over a run, because each insertion starts a new residency. Tools downstream can build length or mass distributions from the stream.

Top module: `resid_mon`

## Requirements
- R1: After reset, all lines are empty, `rec_valid` is 0 and `flush_done` is 0.
- R2: A reference to an empty line allocates the block there and emits no record.
- R3: A reference whose tag matches the valid block in its line adds one to that line's count. The first reference after insertion counts as one, so a block referenced k times reports length k.
- R4: A reference to a valid line holding a different tag evicts the old block. In the cycle after the reference, a record appears with `rec_valid`=1, the line index and the old length. The new block then starts at length 1.
- R5: The line index is (addr / LINE_BYTES) mod NUM_LINES and the tag is addr / (LINE_BYTES*NUM_LINES). With the defaults of 2 lines of 2 bytes, the index is address bit 1 and the tag is address bits 7:2.
- R6: The count saturates at 2^CNT_W-1 and does not wrap. With the default CNT_W=8 the limit is 255.
- R7: A one-cycle `run_end` pulse starts a flush. The flush visits the lines in ascending index order, one per cycle, emits a record for each valid line and empties it. Empty lines produce no record.
- R8: Once the scan ends, `flush_done` goes to 1 and stays there until reset. From the flush start onward, references are ignored and produce no record.
- R9: If a block is evicted and later reinserted, each residency is reported separately with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Memory reference strobe |
| ref_addr | input | ADDR_W | Byte address of the reference |
| run_end | input | 1 | End-of-run strobe that starts the flush |
| rec_valid | output | 1 | Residency record valid pulse |
| rec_line | output | IDX_W | Line the residency occupied |
| rec_len | output | CNT_W | Residency length in references |
| flush_done | output | 1 | Flush complete, sticky |

## Verification
The hardest case to reach from the ports is a saturated count. It needs more than 255 back-to-back hits on one block before a conflicting address evicts it. The bench issues 300 references to one address and then a conflicting one, and expects a record of 255. The second hard case is the ordering of records during a flush when the lines are only partly full. One reset pass leaves both lines valid and another leaves only line 1 valid, so the bench confirms that empty lines are skipped and add nothing to the stream. A scoreboard model predicts every record, including repeated insertions of the same block, and flags any record that was not expected.

// File: rtl/resid_pkg.sv
package resid_pkg;

    localparam int DEF_ADDR_W     = 8;
    localparam int DEF_LINE_BYTES = 2;
    localparam int DEF_NUM_LINES  = 2;
    localparam int DEF_CNT_W      = 8;

    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_DONE = 2'd2
    } scan_st_e;

endpackage

// File: rtl/resid_line.sv
module resid_line #(
    parameter int TAG_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             clr,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o,
    output logic             evict_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TAG_W-1:0] tag_q;
    logic             hit;

    assign hit     = valid_o && (tag_q == tag_in);
    assign evict_o = sel && valid_o && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            tag_q   <= '0;
            count_o <= '0;
        end else if (clr) begin
            valid_o <= 1'b0;
        end else if (sel) begin
            if (hit) begin
                if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
            end else begin
                valid_o <= 1'b1;
                tag_q   <= tag_in;
                count_o <= {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
    end

    // R2
    alloc_one_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel && !valid_o && !clr) |-> (valid_o && count_o == 1));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel && hit && !clr) |-> (count_o >= $past(count_o)));

endmodule

// File: rtl/resid_flush.sv
module resid_flush
    import resid_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int IDX_W     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

    scan_st_e st;

    assign busy = (st == SCAN_RUN);
    assign done = (st == SCAN_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SCAN_IDLE;
            ptr <= '0;
        end else begin
            case (st)
                SCAN_IDLE: if (start) begin
                    st  <= SCAN_RUN;
                    ptr <= '0;
                end
                SCAN_RUN: begin
                    if (ptr == LAST) st <= SCAN_DONE;
                    else             ptr <= ptr + 1'b1;
                end
                default: st <= SCAN_DONE;
            endcase
        end
    end

    // R7
    scan_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> (ptr == $past(ptr) + 1'b1));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> done);

endmodule

// File: rtl/resid_mon.sv
module resid_mon
    import resid_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int NUM_LINES  = DEF_NUM_LINES,
    parameter int CNT_W      = DEF_CNT_W,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int TAG_W     = ADDR_W - OFF_W - $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_valid,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              run_end,
    output logic              rec_valid,
    output logic [IDX_W-1:0]  rec_line,
    output logic [CNT_W-1:0]  rec_len,
    output logic              flush_done
);
    logic                 scan_busy;
    logic [IDX_W-1:0]     scan_ptr;
    logic                 ref_ok;
    logic [IDX_W-1:0]     ref_idx;
    logic [TAG_W-1:0]     ref_tag;
    logic [NUM_LINES-1:0] l_valid, l_evict;
    logic [CNT_W-1:0]     l_count [NUM_LINES];

    logic                 ev_any;
    logic [IDX_W-1:0]     ev_idx;
    logic [CNT_W-1:0]     ev_len;

    assign ref_ok  = ref_valid && !scan_busy && !flush_done;
    assign ref_idx = IDX_W'((ref_addr >> OFF_W) % NUM_LINES);
    assign ref_tag = TAG_W'(ref_addr >> (OFF_W + $clog2(NUM_LINES)));

    resid_flush #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_flush (
        .clk   (clk),
        .rst   (rst),
        .start (run_end),
        .busy  (scan_busy),
        .done  (flush_done),
        .ptr   (scan_ptr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        resid_line #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_line (
            .clk     (clk),
            .rst     (rst),
            .sel     (ref_ok && ref_idx == IDX_W'(i)),
            .tag_in  (ref_tag),
            .clr     (scan_busy && scan_ptr == IDX_W'(i)),
            .valid_o (l_valid[i]),
            .count_o (l_count[i]),
            .evict_o (l_evict[i])
        );
    end

    always_comb begin
        ev_any = 1'b0;
        ev_idx = '0;
        ev_len = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (l_evict[i]) begin
                ev_any = 1'b1;
                ev_idx = IDX_W'(i);
                ev_len = l_count[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_line  <= '0;
            rec_len   <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (scan_busy && l_valid[scan_ptr]) begin
                rec_valid <= 1'b1;
                rec_line  <= scan_ptr;
                rec_len   <= l_count[scan_ptr];
            end else if (ev_any) begin
                rec_valid <= 1'b1;
                rec_line  <= ev_idx;
                rec_len   <= ev_len;
            end
        end
    end

    // R4
    len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_len != '0));

    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_done && $past(flush_done)) |-> !rec_valid);

endmodule

// File: tb/sim_resid_mon.sv
module sim_resid_mon;

    typedef struct {
        int    line;
        int    len;
        string req;
    } exp_t;

    logic       clk = 0;
    logic       rst = 1;
    logic       ref_valid = 0;
    logic [7:0] ref_addr = '0;
    logic       run_end = 0;
    logic       rec_valid;
    logic [0:0] rec_line;
    logic [7:0] rec_len;
    logic       flush_done;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    bit m_v[2];
    int m_t[2];
    int m_c[2];

    always #10 clk = ~clk;

    resid_mon u0 (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_addr(ref_addr),
        .run_end(run_end), .rec_valid(rec_valid), .rec_line(rec_line),
        .rec_len(rec_len), .flush_done(flush_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every record
    always @(negedge clk) begin
        if (!rst && rec_valid) begin
            if (q.size() == 0) begin
                check(0, "R8", "unexpected record len", int'(rec_len), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(rec_line) == e.line, e.req, "record line", int'(rec_line), e.line);
                check(int'(rec_len) == e.len, e.req, "record len", int'(rec_len), e.len);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 2; i++) begin m_v[i] = 0; m_t[i] = 0; m_c[i] = 0; end
    endtask

    // driver: model predicts R2..R6, R9 and pushes expected records
    task automatic do_ref(input int addr, input string req);
        int idx, tag;
        idx = (addr >> 1) & 1;
        tag = (addr >> 2) & 63;
        if (m_v[idx] && m_t[idx] == tag) begin
            if (m_c[idx] < 255) m_c[idx]++;
        end else begin
            if (m_v[idx]) q.push_back('{idx, m_c[idx], req});
            m_v[idx] = 1; m_t[idx] = tag; m_c[idx] = 1;
        end
        ref_valid = 1;
        ref_addr  = 8'(addr);
        @(negedge clk);
        ref_valid = 0;
    endtask

    task automatic do_flush();
        for (int i = 0; i < 2; i++)
            if (m_v[i]) begin q.push_back('{i, m_c[i], "R7"}); m_v[i] = 0; end
        run_end = 1;
        @(negedge clk);
        run_end = 0;
        for (int n = 0; n < 10 && !flush_done; n++) @(negedge clk);
        check(flush_done == 1, "R8", "flush_done", int'(flush_done), 1);
        @(negedge clk);
        check(q.size() == 0, "R7", "pending records", q.size(), 0);
    endtask

    initial begin
        do_reset();
        // R1
        check(rec_valid == 0, "R1", "rec_valid after reset", int'(rec_valid), 0);
        check(flush_done == 0, "R1", "flush_done after reset", int'(flush_done), 0);

        // R2, R3, R5: fill both lines, hits
        do_ref(0, "R2"); do_ref(1, "R3"); do_ref(3, "R5"); do_ref(2, "R3");
        check(q.size() == 0, "R2", "records after fills", q.size(), 0);
        // R4: conflicts on line 0 (tag 1) then back (R9)
        do_ref(4, "R4"); do_ref(5, "R4"); do_ref(4, "R4");
        do_ref(0, "R9"); do_ref(0, "R9");
        do_ref(4, "R9");
        do_ref(6, "R4"); do_ref(7, "R5");
        do_ref(10, "R5"); do_ref(2, "R9");
        @(negedge clk); @(negedge clk);
        check(q.size() == 0, "R4", "records drained", q.size(), 0);

        // R6: saturate then evict
        for (int i = 0; i < 300; i++) do_ref(8, "R6");
        do_ref(12, "R6");
        @(negedge clk); @(negedge clk);
        check(q.size() == 0, "R6", "saturated record seen", q.size(), 0);

        // R7: both lines valid
        do_flush();
        // R8: references after done ignored
        ref_valid = 1; ref_addr = 8'd20; @(negedge clk);
        ref_addr = 8'd40; @(negedge clk);
        ref_valid = 0;
        @(negedge clk); @(negedge clk);
        check(flush_done == 1, "R8", "flush_done sticky", int'(flush_done), 1);

        // R7: only line 1 valid, line 0 skipped
        do_reset();
        do_ref(2, "R2"); do_ref(3, "R3"); do_ref(2, "R3");
        do_flush();

        // empty flush
        do_reset();
        do_flush();
        check(q.size() == 0, "R7", "empty flush records", q.size(), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule